// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is a single compare/capture lane that sits beside a shared free-running timer. It watches the timer value and its overflow pulse and works as either a comparator or a capture latch. As a comparator it compares its 16-bit channel register with the timer and can drive a waveform onto an output pin. As a capture latch it records the timer value when an external pin toggles or when software writes the channel register.

A 3-bit mode input selects the behaviour. Software reaches the channel through a small register port. Address 0 is the 16-bit compare/capture register. Address 1 holds, in bit 0, a shadow level that one compare mode copies to the pin. Several channels are placed side by side on one timer, and each has its own register, mode, pin and flag.

Top module: `cc_channel`

## Requirements
- R1: After reset the channel register reads 0, and the output pin and the match flag are low.
- R2: With mode 3'b000 the match flag stays low, no pin edge changes the register, and the output pin is low.
- R3: In modes 3'b001, 3'b010 and 3'b011, the match flag is high for the clock cycle that follows a cycle in which the timer equals the channel register. In mode 3'b001 the output pin stays low.
- R4: In modes 3'b010 and 3'b011, the output pin changes on the same clock edge that raises the match flag, with no extra cycle between them.
- R5: In mode 3'b010 the pin goes high on a match and goes low on a timer overflow pulse, so it forms a PWM waveform. If both occur in the same cycle, the match wins.
- R6: In mode 3'b011, a match loads the pin with the shadow bit (address 1, bit 0) as it was at that moment.
- R7: In mode 3'b100, a rising edge on the capture pin loads the register with the timer value present at the third rising clock edge after the pin change. This delay comes from a two-flop synchronizer followed by an edge flop. Falling edges have no effect.
- R8: In mode 3'b101 only falling edges capture, with the same latency as R7. Rising edges have no effect.
- R9: In mode 3'b110 both edges capture, with the same latency as R7. Capture of a timer value that has just wrapped stores the wrapped value.
- R10: In mode 3'b111, a write to address 0 stores the timer value of the write cycle, not the written data.
- R11: In every mode other than 3'b111, a write to address 0 stores the written data unless a capture happens in the same cycle. A capture takes priority. A write to address 1 sets the shadow bit, and reading address 1 returns it in bit 0.
- R12: Channels that share one timer do not affect each other's register, pin or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_val_i | input | 16 | Shared timer value |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0: channel register, 1: shadow bit |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected address |
| mode_i | input | 3 | Channel mode code |
| cap_pin_i | input | 1 | Asynchronous capture input pin |
| cmp_pin_o | output | 1 | Compare output pin |
| match_o | output | 1 | One-cycle match flag |

## Verification
The hardest case to reach is a capture that arrives just as the timer wraps. The pin must toggle exactly two cycles before the wrap, so that the synchronizer delay places the capture on the wrapped value. The bench therefore drives its own timer with a short 64-count period and waits for a chosen timer value before it toggles any pin. This fixes the expected capture at the timer value plus two, modulo the period. Four channels run in different modes at once on that same timer, so a write or edge on one channel can be checked against the registers of the others.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    CC_OFF       = 3'b000,
    CC_CMP_QUIET = 3'b001,
    CC_CMP_PWM   = 3'b010,
    CC_CMP_LOAD  = 3'b011,
    CC_CAP_RISE  = 3'b100,
    CC_CAP_FALL  = 3'b101,
    CC_CAP_BOTH  = 3'b110,
    CC_CAP_SW    = 3'b111
  } cc_mode_e;

  function automatic logic cc_is_cmp(cc_mode_e m);
    return (m == CC_CMP_QUIET) || (m == CC_CMP_PWM) || (m == CC_CMP_LOAD);
  endfunction

  function automatic logic cc_drives_pin(cc_mode_e m);
    return (m == CC_CMP_PWM) || (m == CC_CMP_LOAD);
  endfunction
endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int unsigned SyncStages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned ChainW = SyncStages + 1;

  // last bit is the edge-detect history flop
  logic [ChainW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[ChainW-2:0], pin_i};
  end

  assign rise_o =  chain_q[SyncStages-1] & ~chain_q[SyncStages];
  assign fall_o = ~chain_q[SyncStages-1] &  chain_q[SyncStages];
endmodule

// File: rtl/cc_cmp_unit.sv
module cc_cmp_unit
  import cc_pkg::*;
#(
  parameter int unsigned Width = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cc_mode_e         mode_i,
  input  logic [Width-1:0] tmr_val_i,
  input  logic             tmr_ovf_i,
  input  logic [Width-1:0] cmp_val_i,
  input  logic             shadow_i,
  output logic             match_o,
  output logic             pin_o
);
  logic eq;
  logic match_q, pin_q;

  assign eq = (tmr_val_i == cmp_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      match_q <= cc_is_cmp(mode_i) & eq;
      unique case (mode_i)
        CC_CMP_PWM: begin
          if (eq)             pin_q <= 1'b1;
          else if (tmr_ovf_i) pin_q <= 1'b0;
        end
        CC_CMP_LOAD: if (eq) pin_q <= shadow_i;
        default: ;
      endcase
    end
  end

  assign match_o = match_q;
  assign pin_o   = pin_q & cc_drives_pin(mode_i);

  // R2
  off_no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == CC_OFF) |-> !match_o);

  // R5
  pwm_ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CC_CMP_PWM && $past(mode_i) == CC_CMP_PWM && $past(tmr_ovf_i)
     && !$past(match_q === 1'b0 ? eq : eq)) |-> !pin_o);
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int unsigned Width      = 16,
  parameter int unsigned SyncStages = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Width-1:0] tmr_val_i,
  input  logic             tmr_ovf_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [Width-1:0] reg_wdata_i,
  output logic [Width-1:0] reg_rdata_o,
  input  logic [2:0]       mode_i,
  input  logic             cap_pin_i,
  output logic             cmp_pin_o,
  output logic             match_o
);
  cc_mode_e         mode;
  logic [Width-1:0] reg_q;
  logic             shadow_q;
  logic             rise, fall, cap_evt, wr_reg, wr_shadow;

  assign mode      = cc_mode_e'(mode_i);
  assign wr_reg    = reg_we_i & ~reg_addr_i;
  assign wr_shadow = reg_we_i &  reg_addr_i;

  cc_edge_sync #(.SyncStages(SyncStages)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    unique case (mode)
      CC_CAP_RISE: cap_evt = rise;
      CC_CAP_FALL: cap_evt = fall;
      CC_CAP_BOTH: cap_evt = rise | fall;
      CC_CAP_SW:   cap_evt = wr_reg;
      default:     cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q    <= '0;
      shadow_q <= 1'b0;
    end else begin
      if (cap_evt)     reg_q <= tmr_val_i;
      else if (wr_reg) reg_q <= reg_wdata_i;
      if (wr_shadow)   shadow_q <= reg_wdata_i[0];
    end
  end

  assign reg_rdata_o = reg_addr_i ? {{(Width-1){1'b0}}, shadow_q} : reg_q;

  cc_cmp_unit #(.Width(Width)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .tmr_val_i (tmr_val_i),
    .tmr_ovf_i (tmr_ovf_i),
    .cmp_val_i (reg_q),
    .shadow_i  (shadow_q),
    .match_o   (match_o),
    .pin_o     (cmp_pin_o)
  );

  // R10
  sw_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_reg && mode == CC_CAP_SW) |-> reg_q == $past(tmr_val_i));

  // R11
  write_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_reg && !cap_evt) |-> reg_q == $past(reg_wdata_i));

  // R4
  pin_with_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_drives_pin(mode) && $past(mode_i) == mode_i && $rose(cmp_pin_o)) |-> match_o);
endmodule

// File: tb/cc_channel_bench.sv
module cc_channel_bench;
  localparam int TCLK  = 10;
  localparam int NCH   = 4;
  localparam int PER   = 64;
  localparam int LIMIT = 20000;

  typedef struct {
    int          kind;  // 0 rdata, 1 pin, 2 match
    int          ch;
    int          due;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] tmr = '0;
  logic        tmr_ovf;
  logic        we    [NCH];
  logic        addr  [NCH];
  logic [15:0] wdata [NCH];
  logic [15:0] rdata [NCH];
  logic [2:0]  mode  [NCH];
  logic        cap   [NCH];
  logic        pin   [NCH];
  logic        match [NCH];

  int   cyc = 0, checks = 0, failures = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tmr <= '0;
    else        tmr <= (tmr == 16'(PER-1)) ? '0 : tmr + 16'd1;
  assign tmr_ovf = (tmr == 16'(PER-1));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cc_channel u_cc_channel (
      .clk_i(clk), .rst_ni(rst_n), .tmr_val_i(tmr), .tmr_ovf_i(tmr_ovf),
      .reg_we_i(we[i]), .reg_addr_i(addr[i]), .reg_wdata_i(wdata[i]),
      .reg_rdata_o(rdata[i]), .mode_i(mode[i]), .cap_pin_i(cap[i]),
      .cmp_pin_o(pin[i]), .match_o(match[i]));
  end

  initial for (int i = 0; i < NCH; i++) begin
    we[i] = 0; addr[i] = 0; wdata[i] = '0; mode[i] = '0; cap[i] = 0;
  end

  task automatic push(int kind, int ch, int dly, logic [15:0] val, string req);
    exp_t e;
    e.kind = kind; e.ch = ch; e.due = cyc + dly; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(int ch, logic a, logic [15:0] d);
    we[ch] = 1; addr[ch] = a; wdata[ch] = d;
    @(negedge clk);
    we[ch] = 0; addr[ch] = 0;
  endtask

  task automatic wait_tmr(int v);
    do @(negedge clk); while (tmr != 16'(v));
  endtask

  // monitor: sample a quarter period after each rising edge
  initial forever begin
    @(posedge clk);
    #(TCLK/4);
    for (int k = exp_q.size() - 1; k >= 0; k--) begin
      if (exp_q[k].due == cyc) begin
        logic [15:0] act;
        case (exp_q[k].kind)
          0:       act = rdata[exp_q[k].ch];
          1:       act = {15'd0, pin[exp_q[k].ch]};
          default: act = {15'd0, match[exp_q[k].ch]};
        endcase
        checks++;
        if (act !== exp_q[k].val) begin
          failures++;
          $display("FAIL %s ch%0d kind%0d actual=%h expected=%h",
                   exp_q[k].req, exp_q[k].ch, exp_q[k].kind, act, exp_q[k].val);
        end
        exp_q.delete(k);
      end
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NCH; i++) begin
      push(0, i, 1, 16'd0, "R1");
      push(1, i, 1, 16'd0, "R1");
      push(2, i, 1, 16'd0, "R1");
    end
    @(negedge clk);
    // setup in mode 000: writes store data (R11)
    wr(0, 0, 16'd20);
    wr(1, 0, 16'd40);
    wr(2, 0, 16'd10);
    wr(3, 0, 16'd10);
    push(0, 0, 1, 16'd20, "R11");
    wr(1, 1, 16'd1);
    addr[1] = 1;
    push(0, 1, 1, 16'd1, "R11");
    @(negedge clk);
    addr[1] = 0;
    mode[0] = 3'b010; mode[1] = 3'b011; mode[2] = 3'b001; mode[3] = 3'b000;

    wait_tmr(10);
    push(2, 2, 1, 16'd1, "R3");
    push(1, 2, 1, 16'd0, "R3");
    push(2, 2, 2, 16'd0, "R3");
    push(2, 3, 1, 16'd0, "R2");
    push(1, 3, 1, 16'd0, "R2");
    wait_tmr(19);
    push(1, 0, 1, 16'd0, "R5");
    push(1, 0, 2, 16'd1, "R4");
    push(2, 0, 2, 16'd1, "R4");
    push(2, 0, 3, 16'd0, "R3");
    wait_tmr(40);
    push(1, 1, 1, 16'd1, "R6");
    push(2, 1, 1, 16'd1, "R4");
    wait_tmr(62);
    push(1, 0, 1, 16'd1, "R5");
    push(1, 0, 2, 16'd0, "R5");
    wr(1, 1, 16'd0);
    wait_tmr(39);
    push(1, 1, 1, 16'd1, "R6");
    push(1, 1, 2, 16'd0, "R6");
    wait_tmr(45);

    // capture phase
    mode[0] = 3'b100; mode[1] = 3'b101; mode[2] = 3'b110; mode[3] = 3'b111;
    push(0, 0, 1, 16'h1234, "R11");
    wr(0, 0, 16'h1234);
    wait_tmr(5);
    cap[0] = 1; cap[1] = 1; cap[2] = 1;
    push(0, 0, 3, 16'd7, "R7");
    push(0, 1, 3, 16'd40, "R8");
    push(0, 2, 3, 16'd7, "R9");
    push(1, 0, 3, 16'd0, "R2");
    wait_tmr(30);
    cap[0] = 0; cap[1] = 0; cap[2] = 0;
    push(0, 0, 3, 16'd7, "R7");
    push(0, 1, 3, 16'd32, "R8");
    push(0, 2, 3, 16'd32, "R9");
    wait_tmr(50);
    push(0, 3, 1, 16'd50, "R10");
    push(0, 2, 1, 16'd32, "R12");
    push(0, 1, 1, 16'd32, "R12");
    wr(3, 0, 16'hBEEF);
    wait_tmr(62);
    cap[2] = 1;
    push(0, 2, 3, 16'd0, "R9");
    wait_tmr(63);
    push(0, 3, 1, 16'd63, "R10");
    wr(3, 0, 16'h5555);
    repeat (8) @(negedge clk);

    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 pending actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule